// File: doc/BRIEF.md
# Preset-Window Pulse Counter

This block counts single-phase pulses on a 16-bit ring counter, one channel per pulse input, and several channels share one instance. Each channel counts up or down according to its own direction control, and it compares its count with two run-time presets: a turn-on preset and a turn-off preset. When the count steps across a preset, the channel moves a registered window output to a new level and raises a one-clock interrupt strobe for that preset. The presets change roles with the direction. Counting up, passing the turn-on preset opens the window and passing the turn-off preset closes it. Counting down, passing the turn-off preset opens the window and passing the turn-on preset closes it.

The pulse input is asynchronous. It goes through a two-flop synchroniser and a rising-edge detector, so each rising edge gives at most one count step per clock. An enable freezes the channel. A synchronous load writes a start value into the count and closes the window. The channel strobes are packed onto one interrupt vector with two lines per channel: channel k (counting from 0) drives its turn-on strobe on line 2k and its turn-off strobe on line 2k+1.

Top module: `preset_window_counter`

## Requirements
- R1: The count is W bits (default 16) and wraps in both directions: one up step from FFFFh gives 0000h, and one down step from 0000h gives FFFFh.
- R2: After reset every count is 0000h, every window output is 0 and every interrupt line is 0. The first down step after reset gives FFFFh.
- R3: Counting up, a step from a count equal to the turn-on preset sets the window output to 1 and pulses the channel's turn-on line.
- R4: Counting up, a step from a count equal to the turn-off preset clears the window output and pulses the channel's turn-off line.
- R5: Counting down, a step from a count equal to the turn-off preset sets the window output to 1 and pulses the channel's turn-off line.
- R6: Counting down, a step from a count equal to the turn-on preset clears the window output and pulses the channel's turn-on line.
- R7: Each rising edge of a pulse input gives exactly one step. The count, the window output and the strobes all change on the third rising clock edge after the pulse input rises. Each strobe is high for exactly one clock per crossing.
- R8: Channel k (from 0) drives its turn-on strobe on interrupt line 2k and its turn-off strobe on line 2k+1.
- R9: A preset written while counting is used by the very next step.
- R10: While a channel's enable is low, its count and window output do not change and its interrupt lines stay low, even when pulses arrive.
- R11: A load pulse sets the count to the load value one clock later and clears the window output. It raises no strobe, and it takes effect even while enable is low.
- R12: If both presets are equal and a step leaves that value, both strobes of the channel pulse and the window output ends at 0, in either direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pulse_in | input | NUM_CH | Asynchronous count pulses, one bit per channel |
| count_down | input | NUM_CH | Direction per channel: 0 counts up, 1 counts down |
| enable | input | NUM_CH | Counting enable per channel |
| load | input | NUM_CH | Synchronous load strobe per channel |
| load_value | input | NUM_CH*W | Start values, channel k in bits [k*W +: W] |
| on_preset | input | NUM_CH*W | Turn-on presets, channel k in bits [k*W +: W] |
| off_preset | input | NUM_CH*W | Turn-off presets, channel k in bits [k*W +: W] |
| count_out | output | NUM_CH*W | Current counts, channel k in bits [k*W +: W] |
| coin_out | output | NUM_CH | Window output level per channel |
| irq_out | output | 2*NUM_CH | Interrupt strobes, mapped as in R8 |

## Verification
The bench builds the block with its default values: four channels, a 16-bit count and two synchroniser stages. With these values all eight interrupt lines are in use, so the line mapping of every channel can be checked. The full 16-bit wrap is reached in a few pulses, because the bench loads counts next to FFFFh and 0000h and places presets on both sides of the wrap. Two channels run table-driven passes up and down through both presets. The other two channels cover the reset value, a preset rewritten just before a step, disabled counting, a load while disabled, and equal presets.

// File: rtl/pwc_pkg.sv
package pwc_pkg;

    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

    typedef enum logic [1:0] {
        WIN_KEEP  = 2'd0,
        WIN_OPEN  = 2'd1,
        WIN_CLOSE = 2'd2
    } win_act_e;

    typedef struct packed {
        logic on_stb;
        logic off_stb;
    } irq_pair_t;

    // Decide what a step does to the window level, given which presets the
    // departing count matched. Closing wins when both presets match.
    function automatic win_act_e resolve_window(input logic on_hit,
                                                input logic off_hit,
                                                input dir_e dir);
        win_act_e act;
        act = WIN_KEEP;
        if (dir == DIR_UP) begin
            if (off_hit)     act = WIN_CLOSE;
            else if (on_hit) act = WIN_OPEN;
        end else begin
            if (on_hit)       act = WIN_CLOSE;
            else if (off_hit) act = WIN_OPEN;
        end
        return act;
    endfunction

endpackage

// File: rtl/pwc_pulse_sync.sv
module pwc_pulse_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pulse_in,
    output logic step
);
    localparam int CHAIN_LEN = SYNC_STAGES + 1;

    logic [CHAIN_LEN-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain <= {chain[CHAIN_LEN-2:0], pulse_in};
        end
    end

    // rising edge seen at the synchronised end of the chain
    assign step = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

    // R7: an edge detector never reports two steps in a row
    p_single_step_r7: assert property (@(posedge clk) disable iff (rst)
        step |=> !step);

endmodule

// File: rtl/pwc_count_core.sv
module pwc_count_core
    import pwc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         step,
    input  logic         enable,
    input  dir_e         dir,
    input  logic         load,
    input  logic [W-1:0] load_value,
    output logic [W-1:0] count,
    output logic         advance
);
    localparam logic [W-1:0] ONE = W'(1);

    assign advance = step & enable & ~load;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else if (load) begin
            count <= load_value;
        end else if (advance) begin
            if (dir == DIR_UP) count <= count + ONE;
            else               count <= count - ONE;
        end
    end

    // R10: no step and no load means the count stays put
    p_hold_idle_r10: assert property (@(posedge clk) disable iff (rst)
        (!load && !advance) |=> $stable(count));

    // R1: an up step moves the count by exactly one modulo 2**W
    p_up_by_one_r1: assert property (@(posedge clk) disable iff (rst)
        (advance && dir == DIR_UP) |=> ((count - $past(count)) == ONE));

    // R1: a down step moves the count by exactly one modulo 2**W
    p_down_by_one_r1: assert property (@(posedge clk) disable iff (rst)
        (advance && dir == DIR_DOWN) |=> (($past(count) - count) == ONE));

    // R11: load value lands in the count
    p_load_lands_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> (count == $past(load_value)));

endmodule

// File: rtl/pwc_window_cmp.sv
module pwc_window_cmp
    import pwc_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         advance,
    input  logic         load,
    input  dir_e         dir,
    input  logic [W-1:0] count,
    input  logic [W-1:0] on_preset,
    input  logic [W-1:0] off_preset,
    output logic         coin,
    output irq_pair_t    strobes
);
    logic     on_hit;
    logic     off_hit;
    win_act_e act;

    // a crossing is a step that leaves a count equal to the preset
    assign on_hit  = advance && (count == on_preset);
    assign off_hit = advance && (count == off_preset);
    assign act     = resolve_window(on_hit, off_hit, dir);

    always_ff @(posedge clk) begin
        if (rst) begin
            coin    <= 1'b0;
            strobes <= '0;
        end else if (load) begin
            coin    <= 1'b0;
            strobes <= '0;
        end else begin
            strobes.on_stb  <= on_hit;
            strobes.off_stb <= off_hit;
            case (act)
                WIN_OPEN:  coin <= 1'b1;
                WIN_CLOSE: coin <= 1'b0;
                default:   coin <= coin;
            endcase
        end
    end

    // R7: a strobe lasts one clock
    p_on_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        strobes.on_stb |=> !strobes.on_stb);
    p_off_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        strobes.off_stb |=> !strobes.off_stb);

    // R11: load closes the window and raises nothing
    p_load_clears_r11: assert property (@(posedge clk) disable iff (rst)
        load |=> (!coin && !strobes.on_stb && !strobes.off_stb));

    // R3: the window never opens without a crossing strobe
    p_open_has_cause_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(coin) |-> (strobes.on_stb || strobes.off_stb));

    // R4: the window never closes without a crossing strobe or a load
    p_close_has_cause_r4: assert property (@(posedge clk) disable iff (rst)
        $fell(coin) |-> (strobes.on_stb || strobes.off_stb || $past(load)));

    // R12: a double crossing leaves the window closed
    p_equal_closes_r12: assert property (@(posedge clk) disable iff (rst)
        (strobes.on_stb && strobes.off_stb) |-> !coin);

endmodule

// File: rtl/pwc_channel.sv
module pwc_channel
    import pwc_pkg::*;
#(
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         pulse_in,
    input  dir_e         dir,
    input  logic         enable,
    input  logic         load,
    input  logic [W-1:0] load_value,
    input  logic [W-1:0] on_preset,
    input  logic [W-1:0] off_preset,
    output logic [W-1:0] count,
    output logic         coin,
    output irq_pair_t    strobes
);
    logic step;
    logic advance;

    pwc_pulse_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .pulse_in (pulse_in),
        .step     (step)
    );

    pwc_count_core #(.W(W)) u_core (
        .clk        (clk),
        .rst        (rst),
        .step       (step),
        .enable     (enable),
        .dir        (dir),
        .load       (load),
        .load_value (load_value),
        .count      (count),
        .advance    (advance)
    );

    pwc_window_cmp #(.W(W)) u_cmp (
        .clk        (clk),
        .rst        (rst),
        .advance    (advance),
        .load       (load),
        .dir        (dir),
        .count      (count),
        .on_preset  (on_preset),
        .off_preset (off_preset),
        .coin       (coin),
        .strobes    (strobes)
    );

endmodule

// File: rtl/preset_window_counter.sv
module preset_window_counter
    import pwc_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int W           = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_CH-1:0]     pulse_in,
    input  logic [NUM_CH-1:0]     count_down,
    input  logic [NUM_CH-1:0]     enable,
    input  logic [NUM_CH-1:0]     load,
    input  logic [NUM_CH*W-1:0]   load_value,
    input  logic [NUM_CH*W-1:0]   on_preset,
    input  logic [NUM_CH*W-1:0]   off_preset,
    output logic [NUM_CH*W-1:0]   count_out,
    output logic [NUM_CH-1:0]     coin_out,
    output logic [2*NUM_CH-1:0]   irq_out
);
    localparam int IRQ_LINES = 2 * NUM_CH;

    irq_pair_t pairs [NUM_CH];

    for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
        pwc_channel #(.W(W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .pulse_in   (pulse_in[k]),
            .dir        (dir_e'(count_down[k])),
            .enable     (enable[k]),
            .load       (load[k]),
            .load_value (load_value[k*W +: W]),
            .on_preset  (on_preset[k*W +: W]),
            .off_preset (off_preset[k*W +: W]),
            .count      (count_out[k*W +: W]),
            .coin       (coin_out[k]),
            .strobes    (pairs[k])
        );

        // R8: even line carries the turn-on strobe, odd line the turn-off one
        assign irq_out[2*k]     = pairs[k].on_stb;
        assign irq_out[2*k + 1] = pairs[k].off_stb;
    end

    // R2: nothing is pending in the cycle right after reset
    p_quiet_after_reset_r2: assert property (@(posedge clk)
        $fell(rst) |-> (irq_out == '0 && coin_out == '0 && count_out == '0));

    // R7: a lone line never stays high for two clocks
    for (genvar j = 0; j < IRQ_LINES; j++) begin : g_irq_chk
        p_line_pulse_r7: assert property (@(posedge clk) disable iff (rst)
            irq_out[j] |=> !irq_out[j]);
    end

endmodule

// File: tb/sim_preset_window_counter.sv
`timescale 1ns/1ps
module sim_preset_window_counter;
    localparam int NCH = 4;
    localparam int CW  = 16;
    localparam real HALF = 10.0;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    pulse_in = '0;
    logic [NCH-1:0]    count_down = '0;
    logic [NCH-1:0]    enable = '1;
    logic [NCH-1:0]    load = '0;
    logic [NCH*CW-1:0] load_value = '0;
    logic [NCH*CW-1:0] on_preset = '0;
    logic [NCH*CW-1:0] off_preset = '0;
    logic [NCH*CW-1:0] count_out;
    logic [NCH-1:0]    coin_out;
    logic [2*NCH-1:0]  irq_out;

    int n_checks = 0;
    int n_fails  = 0;
    logic [2*NCH-1:0] seen;
    logic [2*NCH-1:0] multi;

    always #(HALF) clk = ~clk;

    preset_window_counter #(.NUM_CH(NCH), .W(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst(rst), .pulse_in(pulse_in), .count_down(count_down),
        .enable(enable), .load(load), .load_value(load_value),
        .on_preset(on_preset), .off_preset(off_preset),
        .count_out(count_out), .coin_out(coin_out), .irq_out(irq_out)
    );

    typedef struct packed {
        logic [1:0]  ch;
        logic        down;
        logic [15:0] cnt;
        logic        coin;
        logic [7:0]  irq;
        logic [3:0]  req;
    } vec_t;

    // ch0: on=0005 off=0008 from 0003 ; ch1: on=FFFF off=0001 from FFFE
    localparam vec_t VEC [19] = '{
        '{2'd0, 1'b0, 16'h0004, 1'b0, 8'h00, 4'd7},   // R7 plain step
        '{2'd0, 1'b0, 16'h0005, 1'b0, 8'h00, 4'd7},
        '{2'd0, 1'b0, 16'h0006, 1'b1, 8'h01, 4'd3},   // R3 leave on-preset up
        '{2'd0, 1'b0, 16'h0007, 1'b1, 8'h00, 4'd3},
        '{2'd0, 1'b0, 16'h0008, 1'b1, 8'h00, 4'd4},
        '{2'd0, 1'b0, 16'h0009, 1'b0, 8'h02, 4'd4},   // R4 leave off-preset up
        '{2'd0, 1'b1, 16'h0008, 1'b0, 8'h00, 4'd5},
        '{2'd0, 1'b1, 16'h0007, 1'b1, 8'h02, 4'd5},   // R5 leave off-preset down
        '{2'd0, 1'b1, 16'h0006, 1'b1, 8'h00, 4'd6},
        '{2'd0, 1'b1, 16'h0005, 1'b1, 8'h00, 4'd6},
        '{2'd0, 1'b1, 16'h0004, 1'b0, 8'h01, 4'd6},   // R6 leave on-preset down
        '{2'd1, 1'b0, 16'hFFFF, 1'b0, 8'h00, 4'd1},
        '{2'd1, 1'b0, 16'h0000, 1'b1, 8'h04, 4'd1},   // R1 wrap up, R8 line 2
        '{2'd1, 1'b0, 16'h0001, 1'b1, 8'h00, 4'd8},
        '{2'd1, 1'b0, 16'h0002, 1'b0, 8'h08, 4'd8},   // R8 line 3
        '{2'd1, 1'b1, 16'h0001, 1'b0, 8'h00, 4'd1},
        '{2'd1, 1'b1, 16'h0000, 1'b1, 8'h08, 4'd5},
        '{2'd1, 1'b1, 16'hFFFF, 1'b1, 8'h00, 4'd1},   // R1 wrap down
        '{2'd1, 1'b1, 16'hFFFE, 1'b0, 8'h04, 4'd6}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic sample_irq();
        multi = multi | (seen & irq_out);
        seen  = seen | irq_out;
    endtask

    // one rising edge on a channel; strobes tracked for six clocks
    task automatic pulse(input int ch, input logic down);
        seen = '0; multi = '0;
        @(negedge clk);
        count_down[ch] = down;
        pulse_in[ch]   = 1'b1;
        for (int i = 0; i < 3; i++) begin @(negedge clk); sample_irq(); end
        pulse_in[ch] = 1'b0;
        for (int i = 0; i < 3; i++) begin @(negedge clk); sample_irq(); end
    endtask

    task automatic do_load(input int ch, input logic [15:0] v);
        seen = '0; multi = '0;
        @(negedge clk);
        load[ch] = 1'b1;
        load_value[ch*CW +: CW] = v;
        @(negedge clk);
        sample_irq();
        load[ch] = 1'b0;
        @(negedge clk);
        sample_irq();
    endtask

    task automatic check_step(input string tag, input int ch, input logic [15:0] cnt,
                              input logic cn, input logic [7:0] irq);
        check({tag, " count"}, 32'(count_out[ch*CW +: CW]), 32'(cnt));
        check({tag, " window"}, 32'(coin_out[ch]), 32'(cn));
        check({tag, " irq"}, {16'(multi), 16'(seen)}, {16'h0, 16'(irq)});
    endtask

    initial begin
        #(HALF * 2.0 * 200000.0);
        n_fails++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        on_preset[0*CW +: CW]  = 16'h0005; off_preset[0*CW +: CW] = 16'h0008;
        on_preset[1*CW +: CW]  = 16'hFFFF; off_preset[1*CW +: CW] = 16'h0001;
        on_preset[2*CW +: CW]  = 16'h1234; off_preset[2*CW +: CW] = 16'h4321;
        on_preset[3*CW +: CW]  = 16'h0010; off_preset[3*CW +: CW] = 16'h0200;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2 reset state
        check("R2 reset counts", 32'(count_out[63:32]) | 32'(count_out[31:0] != 0), 32'h0);
        check("R2 reset window", 32'(coin_out), 32'h0);
        check("R2 reset irq", 32'(irq_out), 32'h0);

        do_load(0, 16'h0003);
        do_load(1, 16'hFFFE);
        check_step("R11 load no strobe", 1, 16'hFFFE, 1'b0, 8'h00);

        for (int v = 0; v < 19; v++) begin
            pulse(int'(VEC[v].ch), VEC[v].down);
            check_step($sformatf("R%0d vec%0d", VEC[v].req, v), int'(VEC[v].ch),
                       VEC[v].cnt, VEC[v].coin, VEC[v].irq);
        end

        // R2 first down step after reset gives FFFF
        pulse(2, 1'b1);
        check_step("R2 first down", 2, 16'hFFFF, 1'b0, 8'h00);

        // R9 preset rewritten right before the step that uses it
        @(negedge clk);
        on_preset[2*CW +: CW] = 16'hFFFF;
        pulse(2, 1'b0);
        check_step("R9 new preset", 2, 16'h0000, 1'b1, 8'h10);

        // R10 disabled channel ignores pulses
        enable[2] = 1'b0;
        on_preset[2*CW +: CW] = 16'h0000;
        pulse(2, 1'b0);
        check_step("R10 hold", 2, 16'h0000, 1'b1, 8'h00);

        // R11 load works while disabled and closes the window
        do_load(2, 16'h0100);
        check_step("R11 load", 2, 16'h0100, 1'b0, 8'h00);
        enable[2] = 1'b1;

        // R12 equal presets: open first, then cross both at once
        do_load(3, 16'h0010);
        pulse(3, 1'b0);
        check_step("R3 ch3 open", 3, 16'h0011, 1'b1, 8'h40);
        @(negedge clk);
        on_preset[3*CW +: CW]  = 16'h0011;
        off_preset[3*CW +: CW] = 16'h0011;
        pulse(3, 1'b0);
        check_step("R12 equal up", 3, 16'h0012, 1'b0, 8'hC0);
        pulse(3, 1'b1);
        check_step("R12 back down", 3, 16'h0011, 1'b0, 8'h00);
        pulse(3, 1'b1);
        check_step("R12 equal down", 3, 16'h0010, 1'b0, 8'hC0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule